// File: doc/BRIEF.md
# Data-Bus Burst Completion Tracker

This block keeps track of when the shared data bus of one memory channel is busy. Each time the controller issues a column read or column write, the block works out the cycle in which that data burst will have finished on the bus. It stores that finish time, together with a request tag and the rank and bank of the access, in an in-order queue. The controller consults two issue-permission outputs before sending a read or a write. These outputs make sure that the new burst cannot collide with the burst queued just before it, and that the queue never overflows.

The block runs a free-running cycle counter that starts at zero when reset ends. It acts only on tick cycles, which are the cycles whose count is a whole multiple of the clock-division parameter. On a tick, when the oldest queued burst has reached its finish time, the block removes it and sends a one-cycle completion pulse that carries that entry's tag, rank and bank. The read latency, write latency and burst length are captured while reset is held.

A three-state machine follows the queue occupancy:
- `BQ_EMPTY`: moves to `BQ_PARTIAL` on a push.
- `BQ_PARTIAL`:
  - stays in `BQ_PARTIAL` when a push and a pop happen together, or when neither happens;
  - moves to `BQ_FULL` on a push alone that fills the last slot;
  - moves to `BQ_EMPTY` on a pop alone that removes the last entry.
- `BQ_FULL`: moves back to `BQ_PARTIAL` on a pop alone.

Top module: `dbus_txn_sched`

## Requirements
- R1: The read latency, write latency and burst length inputs are sampled on every clock edge while `rst_n` is low. Changes to these inputs after reset has ended have no effect on timing.
- R2: A read accepted in the cycle when the counter reads `n` gets the finish time `n + rd_lat + burst`. Its `done_o` pulse appears one cycle after the first tick whose count is greater than or equal to that finish time.
- R3: A write accepted at count `n` gets the finish time `n + wr_lat + burst`. It retires under the same rule as R2.
- R4: When the queue holds entries, a read or a write is permitted only if its finish time is at least `burst` cycles later than the finish time of the newest queued entry. A finish time that would fall earlier than that entry's is refused. When the queue is empty, no spacing rule applies.
- R5: A request on `iss_vld_i` is accepted only if the permission output for its kind (`iss_wr_i` = 1 for a write, 0 for a read) is high. Any other request is dropped and never produces a completion.
- R6: While the queue holds DEPTH entries, `rd_ok_o` and `wr_ok_o` are both low, even if the spacing rule would allow the burst. This lasts until an entry retires.
- R7: The counter is 0 in the first cycle after reset and increases by one every clock. In cycles where the count is not a multiple of CLK_DIV, both permission outputs are low and nothing retires.
- R8: Entries retire in the order they were accepted, with at most one per tick. Each retirement drives `done_o` high for exactly one cycle, with `done_tag_o`, `done_rank_o` and `done_bank_o` equal to that entry's values.
- R9: After reset the queue is empty and `done_o` is low. In the first cycle, which is a tick, both permission outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; the timing inputs are captured while it is low |
| cfg_rd_lat_i | input | LAT_W | Read latency in cycles |
| cfg_wr_lat_i | input | LAT_W | Write latency in cycles |
| cfg_burst_i | input | LAT_W | Burst length in cycles |
| iss_vld_i | input | 1 | A burst is being issued this cycle |
| iss_wr_i | input | 1 | 1 = write, 0 = read |
| iss_tag_i | input | TAG_W | Request tag |
| iss_rank_i | input | RANK_W | Rank of the access |
| iss_bank_i | input | BANK_W | Bank of the access |
| rd_ok_o | output | 1 | A read may be issued this cycle |
| wr_ok_o | output | 1 | A write may be issued this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| done_tag_o | output | TAG_W | Tag of the retired entry |
| done_rank_o | output | RANK_W | Rank of the retired entry |
| done_bank_o | output | BANK_W | Bank of the retired entry |

## Verification
The permission outputs are combinational functions of the counter and the queue, so they are valid in the same cycle in which the bench reads them. The bench drives inputs and samples outputs at the falling clock edge, half a cycle away from the edge that updates the design. A request is accepted at the next rising edge. A retirement happens at the first tick at or after the finish time, and `done_o` shows it one cycle later through a register. The bench keeps its own count of cycles since reset. From that count it computes the due cycle as `roundup_to_tick(n + latency + burst) + 1`, and it compares that value with the cycle in which it saw each pulse.

// File: rtl/dbus_sched_pkg.sv
package dbus_sched_pkg;

    // Occupancy states of the burst queue
    typedef enum logic [1:0] {
        BQ_EMPTY   = 2'd0,
        BQ_PARTIAL = 2'd1,
        BQ_FULL    = 2'd2
    } bq_state_e;

endpackage

// File: rtl/dbus_tick_gen.sv
module dbus_tick_gen #(
    parameter int CLK_DIV = 2,
    parameter int TS_W    = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now_o,
    output logic            tick_o
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    always_ff @(posedge clk) begin
        if (!rst_n) now_o <= '0;
        else        now_o <= now_o + 1'b1;
    end

    // A side counter marks ticks, so no divider is needed on now_o
    generate
        if (CLK_DIV == 1) begin : g_nodiv
            assign tick_o = 1'b1;
        end else begin : g_div
            logic [DIV_W-1:0] div_q;
            always_ff @(posedge clk) begin
                if (!rst_n)                             div_q <= '0;
                else if (div_q == DIV_W'(CLK_DIV - 1))  div_q <= '0;
                else                                    div_q <= div_q + 1'b1;
            end
            assign tick_o = (div_q == '0);
        end
    endgenerate

endmodule

// File: rtl/dbus_slot_check.sv
module dbus_slot_check #(
    parameter int LAT_W = 8,
    parameter int TS_W  = 32
) (
    input  logic [TS_W-1:0]  now_i,
    input  logic [LAT_W-1:0] lat_i,
    input  logic [LAT_W-1:0] burst_i,
    input  logic [TS_W-1:0]  last_ts_i,
    input  logic             have_last_i,
    output logic [TS_W-1:0]  done_ts_o,
    output logic             fits_o
);
    logic [TS_W-1:0] gap;
    logic [TS_W-1:0] burst_ext;

    assign burst_ext = TS_W'(burst_i);
    assign done_ts_o = now_i + TS_W'(lat_i) + burst_ext;
    assign gap       = done_ts_o - last_ts_i;

    // A negative gap means the new burst would finish before the newest one
    assign fits_o = !have_last_i || (!gap[TS_W-1] && (gap >= burst_ext));

endmodule

// File: rtl/dbus_txn_fifo.sv
module dbus_txn_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic                       pop_i,
    input  logic [W-1:0]               din_i,
    output logic [W-1:0]               head_o,
    output logic [W-1:0]               tail_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, last_ptr;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_i) mem[wr_ptr] <= din_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            last_ptr <= '0;
            cnt_o    <= '0;
        end else begin
            if (push_i) begin
                wr_ptr   <= ptr_inc(wr_ptr);
                last_ptr <= wr_ptr;
            end
            if (pop_i) rd_ptr <= ptr_inc(rd_ptr);
            unique case ({push_i, pop_i})
                2'b10:   cnt_o <= cnt_o + CNT_W'(1);
                2'b01:   cnt_o <= cnt_o - CNT_W'(1);
                default: cnt_o <= cnt_o;
            endcase
        end
    end

    assign head_o = mem[rd_ptr];
    assign tail_o = mem[last_ptr];

endmodule

// File: rtl/dbus_txn_sched.sv
module dbus_txn_sched
    import dbus_sched_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int TAG_W   = 4,
    parameter int RANK_W  = 1,
    parameter int BANK_W  = 3,
    parameter int LAT_W   = 8,
    parameter int TS_W    = 32,
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAT_W-1:0]  cfg_rd_lat_i,
    input  logic [LAT_W-1:0]  cfg_wr_lat_i,
    input  logic [LAT_W-1:0]  cfg_burst_i,
    input  logic              iss_vld_i,
    input  logic              iss_wr_i,
    input  logic [TAG_W-1:0]  iss_tag_i,
    input  logic [RANK_W-1:0] iss_rank_i,
    input  logic [BANK_W-1:0] iss_bank_i,
    output logic              rd_ok_o,
    output logic              wr_ok_o,
    output logic              done_o,
    output logic [TAG_W-1:0]  done_tag_o,
    output logic [RANK_W-1:0] done_rank_o,
    output logic [BANK_W-1:0] done_bank_o
);
    localparam int ENT_W = TS_W + TAG_W + RANK_W + BANK_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [TS_W-1:0]   ts;
        logic [TAG_W-1:0]  tag;
        logic [RANK_W-1:0] rank;
        logic [BANK_W-1:0] bank;
    } ent_t;

    // Timing parameters captured during reset
    logic [LAT_W-1:0] rd_lat_q, wr_lat_q, bl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_lat_q <= cfg_rd_lat_i;
            wr_lat_q <= cfg_wr_lat_i;
            bl_q     <= cfg_burst_i;
        end
    end

    logic [TS_W-1:0] now;
    logic            tick;

    dbus_tick_gen #(.CLK_DIV(CLK_DIV), .TS_W(TS_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .now_o  (now),
        .tick_o (tick)
    );

    bq_state_e       state_q, state_d;
    logic            push, pop;
    logic [CNT_W-1:0] q_cnt;
    logic [ENT_W-1:0] head_raw, tail_raw;
    ent_t            head_ent, tail_ent, new_ent;
    logic [TS_W-1:0] head_ts, tail_ts;

    assign head_ent = ent_t'(head_raw);
    assign tail_ent = ent_t'(tail_raw);
    assign head_ts  = head_ent.ts;
    assign tail_ts  = tail_ent.ts;

    // Spacing check per burst kind: index 0 read, index 1 write
    logic [TS_W-1:0] kind_ts  [2];
    logic [1:0]      kind_fits;

    generate
        for (genvar k = 0; k < 2; k++) begin : g_kind
            dbus_slot_check #(.LAT_W(LAT_W), .TS_W(TS_W)) u_slot (
                .now_i       (now),
                .lat_i       ((k == 0) ? rd_lat_q : wr_lat_q),
                .burst_i     (bl_q),
                .last_ts_i   (tail_ts),
                .have_last_i (state_q != BQ_EMPTY),
                .done_ts_o   (kind_ts[k]),
                .fits_o      (kind_fits[k])
            );
        end
    endgenerate

    always_comb begin
        new_ent.ts   = iss_wr_i ? kind_ts[1] : kind_ts[0];
        new_ent.tag  = iss_tag_i;
        new_ent.rank = iss_rank_i;
        new_ent.bank = iss_bank_i;
    end

    assign push = iss_vld_i && (iss_wr_i ? wr_ok_o : rd_ok_o);

    dbus_txn_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push),
        .pop_i  (pop),
        .din_i  (new_ent),
        .head_o (head_raw),
        .tail_o (tail_raw),
        .cnt_o  (q_cnt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BQ_EMPTY;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BQ_EMPTY: begin
                if (push) state_d = BQ_PARTIAL;
            end
            BQ_PARTIAL: begin
                if (push && !pop && (q_cnt == CNT_W'(DEPTH - 1)))     state_d = BQ_FULL;
                else if (pop && !push && (q_cnt == CNT_W'(1)))        state_d = BQ_EMPTY;
            end
            BQ_FULL: begin
                if (pop && !push) state_d = BQ_PARTIAL;
            end
            default: state_d = BQ_EMPTY;
        endcase
    end

    // Outputs: issue permission and retirement
    always_comb begin
        rd_ok_o = 1'b0;
        wr_ok_o = 1'b0;
        pop     = 1'b0;
        unique case (state_q)
            BQ_EMPTY: begin
                rd_ok_o = tick;
                wr_ok_o = tick;
            end
            BQ_PARTIAL: begin
                rd_ok_o = tick && kind_fits[0];
                wr_ok_o = tick && kind_fits[1];
                pop     = tick && (head_ts <= now);
            end
            BQ_FULL: begin
                pop     = tick && (head_ts <= now);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            done_tag_o  <= '0;
            done_rank_o <= '0;
            done_bank_o <= '0;
        end else begin
            done_o <= pop;
            if (pop) begin
                done_tag_o  <= head_ent.tag;
                done_rank_o <= head_ent.rank;
                done_bank_o <= head_ent.bank;
            end
        end
    end

endmodule

// File: rtl/dbus_txn_sched_chk.sv
module dbus_txn_sched_chk
    import dbus_sched_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int LAT_W   = 8,
    parameter int TS_W    = 32,
    parameter int CLK_DIV = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [TS_W-1:0]            now,
    input logic                       rd_ok,
    input logic                       wr_ok,
    input logic                       done,
    input logic                       push,
    input logic                       pop,
    input logic [$clog2(DEPTH+1)-1:0] cnt,
    input logic [TS_W-1:0]            tail_ts,
    input logic [TS_W-1:0]            head_ts,
    input logic [LAT_W-1:0]           bl,
    input bq_state_e                  state
);
    logic [TS_W-1:0] prev_tail;
    logic [TS_W-1:0] tdiff;

    always_ff @(posedge clk) prev_tail <= tail_ts;
    assign tdiff = tail_ts - prev_tail;

    // R6
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= DEPTH);

    // R6
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt) == DEPTH) |-> !push);

    // R9
    empty_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BQ_EMPTY) == (cnt == '0));

    // R7
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((now % CLK_DIV) != 0) |-> (!rd_ok && !wr_ok && !pop));

    // R4
    spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cnt != '0) |=> (!tdiff[TS_W-1] && tdiff >= TS_W'(bl)));

    // R8
    retire_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(head_ts) <= $past(now)));

    generate
        if (CLK_DIV > 1) begin : g_pulse
            // R8
            one_per_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
                done |=> !done);
        end
    endgenerate

endmodule

bind dbus_txn_sched dbus_txn_sched_chk #(
    .DEPTH(DEPTH), .LAT_W(LAT_W), .TS_W(TS_W), .CLK_DIV(CLK_DIV)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .now     (now),
    .rd_ok   (rd_ok_o),
    .wr_ok   (wr_ok_o),
    .done    (done_o),
    .push    (push),
    .pop     (pop),
    .cnt     (q_cnt),
    .tail_ts (tail_ts),
    .head_ts (head_ts),
    .bl      (bl_q),
    .state   (state_q)
);

// File: tb/test_dbus_txn_sched.sv
module test_dbus_txn_sched;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4, TAG_W = 4, RANK_W = 1, BANK_W = 3, LAT_W = 8, CLK_DIV = 2;

    // table row: {wr, tag[3:0], rank, bank[2:0]}
    localparam int NVEC = 6;
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b0, 4'h1, 1'b0, 3'd0},
        {1'b1, 4'h2, 1'b1, 3'd5},
        {1'b0, 4'h7, 1'b1, 3'd7},
        {1'b1, 4'hA, 1'b0, 3'd3},
        {1'b0, 4'hF, 1'b0, 3'd6},
        {1'b1, 4'h0, 1'b1, 3'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [LAT_W-1:0] cfg_rd, cfg_wr, cfg_bl;
    logic iss_vld = 1'b0, iss_wr = 1'b0;
    logic [TAG_W-1:0] iss_tag = '0;
    logic [RANK_W-1:0] iss_rank = '0;
    logic [BANK_W-1:0] iss_bank = '0;
    logic rd_ok, wr_ok, done;
    logic [TAG_W-1:0] done_tag;
    logic [RANK_W-1:0] done_rank;
    logic [BANK_W-1:0] done_bank;

    int errors = 0, checks = 0;
    int bnow = 0;
    int cur_rd = 20, cur_wr = 14, cur_bl = 4;
    int log_n = 0;
    int log_t [64];
    logic [TAG_W-1:0] log_tag [64];
    logic [RANK_W-1:0] log_rank [64];
    logic [BANK_W-1:0] log_bank [64];

    dbus_txn_sched #(.DEPTH(DEPTH), .TAG_W(TAG_W), .RANK_W(RANK_W), .BANK_W(BANK_W),
                     .LAT_W(LAT_W), .CLK_DIV(CLK_DIV)) i_dbus_txn_sched (
        .clk(clk), .rst_n(rst_n),
        .cfg_rd_lat_i(cfg_rd), .cfg_wr_lat_i(cfg_wr), .cfg_burst_i(cfg_bl),
        .iss_vld_i(iss_vld), .iss_wr_i(iss_wr), .iss_tag_i(iss_tag),
        .iss_rank_i(iss_rank), .iss_bank_i(iss_bank),
        .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .done_o(done),
        .done_tag_o(done_tag), .done_rank_o(done_rank), .done_bank_o(done_bank)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) bnow <= 0;
        else        bnow <= bnow + 1;
    end

    always @(negedge clk) begin
        if (rst_n && done) begin
            if (log_n < 64) begin
                log_t[log_n]    = bnow;
                log_tag[log_n]  = done_tag;
                log_rank[log_n] = done_rank;
                log_bank[log_n] = done_bank;
            end
            log_n = log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic to_tick();
        while ((bnow % CLK_DIV) != 0) step();
    endtask

    task automatic issue(input bit wr, input logic [TAG_W-1:0] tag,
                         input logic [RANK_W-1:0] rk, input logic [BANK_W-1:0] bk);
        iss_vld = 1'b1; iss_wr = wr; iss_tag = tag; iss_rank = rk; iss_bank = bk;
        step();
        iss_vld = 1'b0;
    endtask

    function automatic int exp_done(input int n, input bit wr);
        int ts = n + (wr ? cur_wr : cur_rd) + cur_bl;
        while ((ts % CLK_DIV) != 0) ts++;
        return ts + 1;
    endfunction

    task automatic do_reset(input int rl, input int wl, input int bl);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_rd = LAT_W'(rl); cfg_wr = LAT_W'(wl); cfg_bl = LAT_W'(bl);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_rd = rl; cur_wr = wl; cur_bl = bl;
    endtask

    initial begin
        int n0, base;
        do_reset(20, 14, 4);
        // Post-reset inputs differ; R1 says they must be ignored
        cfg_rd = 8'd2; cfg_wr = 8'd2; cfg_bl = 8'd1;

        // r9_ reset state, first cycle is a tick
        chk(done == 1'b0, "R9", "done after reset", int'(done), 0);
        chk(rd_ok == 1'b1, "R9", "rd_ok at count 0", int'(rd_ok), 1);
        chk(wr_ok == 1'b1, "R9", "wr_ok at count 0", int'(wr_ok), 1);
        step();
        chk(rd_ok == 1'b0 && wr_ok == 1'b0, "R7", "ok on non-tick", int'({rd_ok, wr_ok}), 0);

        // Table walk: single bursts on an empty queue
        for (int i = 0; i < NVEC; i++) begin
            bit wr;
            int n;
            wr = VEC[i][8];
            to_tick();
            chk((wr ? wr_ok : rd_ok) == 1'b1, "R4", "empty queue permits", int'(wr ? wr_ok : rd_ok), 1);
            n = bnow; base = log_n;
            issue(wr, VEC[i][7:4], VEC[i][3], VEC[i][2:0]);
            for (int w = 0; w < 100 && log_n <= base; w++) step();
            chk(log_t[base] == exp_done(n, wr), wr ? "R3 R1" : "R2 R1", "done cycle",
                log_t[base], exp_done(n, wr));
            chk(log_tag[base] == VEC[i][7:4], "R8", "done tag", int'(log_tag[base]), int'(VEC[i][7:4]));
            chk(log_rank[base] == VEC[i][3], "R8", "done rank", int'(log_rank[base]), int'(VEC[i][3]));
            chk(log_bank[base] == VEC[i][2:0], "R8", "done bank", int'(log_bank[base]), int'(VEC[i][2:0]));
        end

        // Spacing and dropped request
        to_tick(); n0 = bnow; base = log_n;
        issue(1'b0, 4'h1, 1'b0, 3'd2);
        chk(rd_ok == 1'b0, "R7", "rd_ok off-tick after issue", int'(rd_ok), 0);
        step();
        chk(rd_ok == 1'b0, "R4", "read 2 cycles behind", int'(rd_ok), 0);
        chk(wr_ok == 1'b0, "R4", "write finishing earlier", int'(wr_ok), 0);
        issue(1'b0, 4'hE, 1'b1, 3'd4);   // refused attempt, R5
        step();
        chk(rd_ok == 1'b1, "R4", "read one burst later", int'(rd_ok), 1);
        chk(wr_ok == 1'b0, "R4", "write still too early", int'(wr_ok), 0);
        while (bnow < n0 + 10) step();
        chk(wr_ok == 1'b1, "R4", "write spaced by burst", int'(wr_ok), 1);
        issue(1'b1, 4'h2, 1'b0, 3'd1);
        repeat (60) step();
        chk(log_n - base == 2, "R5", "completions after refusal", log_n - base, 2);
        chk(log_tag[base] == 4'h1 && log_tag[base+1] == 4'h2, "R8", "completion order",
            int'({log_tag[base], log_tag[base+1]}), 8'h12);
        chk(log_t[base] == exp_done(n0, 1'b0), "R2", "first done cycle", log_t[base], exp_done(n0, 1'b0));
        chk(log_t[base+1] == exp_done(n0 + 10, 1'b1), "R3", "write done cycle",
            log_t[base+1], exp_done(n0 + 10, 1'b1));

        // Fill the queue
        to_tick(); n0 = bnow; base = log_n;
        for (int k = 0; k < DEPTH; k++) begin
            issue(1'b0, TAG_W'(3 + k), 1'b0, 3'(k));
            repeat (3) step();
        end
        chk(rd_ok == 1'b0 && wr_ok == 1'b0, "R6", "full blocks both", int'({rd_ok, wr_ok}), 0);
        while (bnow < n0 + 22) step();
        chk(rd_ok == 1'b0, "R6", "still full before retire", int'(rd_ok), 0);
        while (bnow < n0 + 26) step();
        chk(rd_ok == 1'b1, "R6", "read allowed after retire", int'(rd_ok), 1);
        repeat (40) step();
        chk(log_n - base == DEPTH, "R8", "all retired", log_n - base, DEPTH);
        for (int k = 0; k < DEPTH; k++) begin
            chk(log_tag[base+k] == TAG_W'(3 + k), "R8", "in-order tag", int'(log_tag[base+k]), 3 + k);
            chk(log_t[base+k] == exp_done(n0 + 4*k, 1'b0), "R8", "retire cycle",
                log_t[base+k], exp_done(n0 + 4*k, 1'b0));
        end

        // Second reset with new timing: r1_ sampling
        do_reset(6, 10, 2);
        cfg_rd = 8'd30; cfg_wr = 8'd30; cfg_bl = 8'd30;
        base = log_n; n0 = bnow;
        issue(1'b1, 4'h9, 1'b1, 3'd2);
        repeat (30) step();
        chk(log_t[base] == exp_done(n0, 1'b1), "R1", "write with re-sampled timing",
            log_t[base], exp_done(n0, 1'b1));
        to_tick(); n0 = bnow; base = log_n;
        issue(1'b0, 4'h4, 1'b0, 3'd0);
        repeat (30) step();
        chk(log_t[base] == exp_done(n0, 1'b0), "R1", "read with re-sampled timing",
            log_t[base], exp_done(n0, 1'b0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule